// File: doc/BRIEF.md
# Two-Wire Bus Clock Generator

This block produces the serial clock for a two-wire bus master. A programmable prescaler first divides the system clock into a reference tick, nominally 10 MHz. The serial clock then spends a programmed number of reference ticks low and a separately programmed number high. The 16-bit divider input carries both counts: the high-time count sits in the upper byte and the low-time count in the lower byte. The bus rate is therefore the reference rate divided by the sum of the two counts. With equal halves, that is half the reference rate divided by either count. Counts from 13 to 255 cover roughly 20 kHz to 400 kHz when the reference is 10 MHz.

The bus engine drives two inputs, the block enable and a clock request. While either is low, the serial clock is released high and every counter stays cleared. Once both are high, the clock starts with a full low phase. Each half period carries one single-cycle strobe at its midpoint. The strobe in the low half marks where the engine may change the data line, and the strobe in the high half marks where it samples the data line.

Top module: `busClockGen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclOut` is 1, and `refTick`, `lowMidStb` and `highMidStb` are 0.
- R2: While running, `refTick` is a one-cycle pulse that repeats every P system clocks. P is the value of `prescale`, except that a `prescale` of 0 gives P = 1.
- R3: Each low phase of `sclOut` lasts exactly L*P system clocks, where L is `divider[7:0]`.
- R4: Each high phase of `sclOut` lasts exactly H*P system clocks, where H is `divider[15:8]`.
- R5: Suppose `enable` and `clkReq` are both 1 at a clock edge after an inactive cycle. Then `sclOut` is 0 from that edge on, and the low phase starts there. The waveform repeats with a period of (L+H)*P clocks.
- R6: A divider field of 0 behaves as a count of 1 reference tick.
- R7: Whenever `enable` or `clkReq` is 0 at an edge, `sclOut` is 1 after that edge. In the same cycle no tick or strobe is driven, and the counters restart from zero on reactivation.
- R8: `lowMidStb` pulses for one cycle in each low phase, on reference tick number floor((L-1)/2)+1 of that phase (counting from 1).
- R9: `highMidStb` pulses for one cycle in each high phase, on reference tick number floor((H-1)/2)+1 of that phase.
- R10: The two strobes are never 1 in the same cycle. Each strobe coincides with a `refTick`, and each appears only while `sclOut` is at the level of its own phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| clkReq | input | 1 | Bus engine requests a running clock |
| prescale | input | 7 | System clocks per reference tick (0 acts as 1) |
| divider | input | 16 | Upper byte: high-time count; lower byte: low-time count |
| sclOut | output | 1 | Serial clock level |
| refTick | output | 1 | Reference tick pulse |
| lowMidStb | output | 1 | Midpoint of low phase (data may change) |
| highMidStb | output | 1 | Midpoint of high phase (data is sampled) |

## Verification
Some properties can be judged one cycle at a time, and the assertions check these on every cycle. They cover the idle state of the clock and strobes, the exclusivity of the two strobes, the alignment of each strobe with a tick and with its own phase level, and the rule that the clock only rises on a tick or on deactivation. The exact lengths of the phases, the tick spacing for a given prescale, the positions of the midpoints and the period across two full cycles depend on how the counts build up. Only the bench's scenarios can show these. The bench compares each sampled cycle against a position computed from the programmed values, under both directed and random settings. The directed cases include the zero-prescale, zero-field and widest-count settings.

// File: rtl/busClockPkg.sv
package busClockPkg;
  // strobes from the control side to the phase datapath
  typedef struct packed {
    logic clear;  // inactive: hold everything at rest
    logic start;  // first active cycle: begin a low phase
    logic tick;   // one reference tick elapsed
  } ctrlStb_t;
endpackage

// File: rtl/busClockCtrl.sv
module busClockCtrl
  import busClockPkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clkReq,
  input  logic [PRE_W-1:0] prescale,
  output ctrlStb_t         stb
);
  logic             active;
  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic [PRE_W-1:0] preLast;

  assign active  = enable & clkReq;
  // R2: a prescale of zero acts as one
  assign preLim  = (prescale == '0) ? PRE_W'(1) : prescale;
  assign preLast = preLim - PRE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else if (!active) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else if (!running) begin
      running <= 1'b1;
      preCnt  <= '0;
    end else if (preCnt == preLast) begin
      preCnt  <= '0;
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    stb.clear = ~active;
    stb.start = active & ~running;
    stb.tick  = active & running & (preCnt == preLast);
  end
endmodule

// File: rtl/busClockPath.sv
module busClockPath
  import busClockPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [CNT_W-1:0] hiCnt,
  input  logic [CNT_W-1:0] loCnt,
  output logic             sclOut,
  output logic             lowMidStb,
  output logic             highMidStb
);
  logic             phaseHigh;
  logic [CNT_W-1:0] phCnt;
  logic [CNT_W-1:0] effHi;
  logic [CNT_W-1:0] effLo;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] midIdx;
  logic             midHit;

  // R6: zero-length field behaves as one tick
  assign effHi   = (hiCnt == '0) ? CNT_W'(1) : hiCnt;
  assign effLo   = (loCnt == '0) ? CNT_W'(1) : loCnt;
  assign limit   = phaseHigh ? effHi : effLo;
  assign lastIdx = limit - CNT_W'(1);
  assign midIdx  = lastIdx >> 1;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      phaseHigh <= 1'b1;
      phCnt     <= '0;
    end else if (stb.start) begin
      phaseHigh <= 1'b0;
      phCnt     <= '0;
    end else if (stb.tick) begin
      if (phCnt == lastIdx) begin
        phCnt     <= '0;
        phaseHigh <= ~phaseHigh;
      end else begin
        phCnt     <= phCnt + CNT_W'(1);
      end
    end
  end

  assign midHit     = stb.tick & (phCnt == midIdx);
  assign lowMidStb  = midHit & ~phaseHigh;
  assign highMidStb = midHit & phaseHigh;
  assign sclOut     = phaseHigh;
endmodule

// File: rtl/busClockGen.sv
module busClockGen
  import busClockPkg::*;
#(
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               clkReq,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [2*CNT_W-1:0] divider,
  output logic               sclOut,
  output logic               refTick,
  output logic               lowMidStb,
  output logic               highMidStb
);
  localparam int DIV_W = 2 * CNT_W;

  ctrlStb_t stb;

  busClockCtrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .clkReq   (clkReq),
    .prescale (prescale),
    .stb      (stb)
  );

  busClockPath #(.CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hiCnt      (divider[DIV_W-1:CNT_W]),
    .loCnt      (divider[CNT_W-1:0]),
    .sclOut     (sclOut),
    .lowMidStb  (lowMidStb),
    .highMidStb (highMidStb)
  );

  assign refTick = stb.tick;
endmodule

// File: rtl/busClockChk.sv
module busClockChk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic clkReq,
  input logic sclOut,
  input logic refTick,
  input logic lowMidStb,
  input logic highMidStb
);
  // R7
  idle_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && clkReq) |=> sclOut);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && clkReq) |-> (!refTick && !lowMidStb && !highMidStb));

  // R10
  stb_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lowMidStb && highMidStb));

  // R8
  low_stb_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowMidStb |-> (!sclOut && refTick));

  // R9
  high_stb_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    highMidStb |-> (sclOut && refTick));

  // R3
  scl_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOut) |-> ($past(refTick) || !$past(enable && clkReq)));
endmodule

bind busClockGen busClockChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .clkReq     (clkReq),
  .sclOut     (sclOut),
  .refTick    (refTick),
  .lowMidStb  (lowMidStb),
  .highMidStb (highMidStb)
);

// File: tb/busClockGen_tb.sv
module busClockGen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        clkReq = 1'b0;
  logic [6:0]  prescale = 7'd1;
  logic [15:0] divider = 16'h0d0d;
  logic        sclOut, refTick, lowMidStb, highMidStb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  busClockGen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkReq(clkReq),
    .prescale(prescale), .divider(divider),
    .sclOut(sclOut), .refTick(refTick),
    .lowMidStb(lowMidStb), .highMidStb(highMidStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int effVal(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected level at sample t (t = 0 is just after the first active edge)
  function automatic bit expScl(int t, int p, int l, int h);
    int pos = t % ((l + h) * p);
    return pos >= l * p;
  endfunction

  function automatic bit expTick(int t, int p);
    return (t % p) == p - 1;
  endfunction

  function automatic bit expLowStb(int t, int p, int l, int h);
    int pos = t % ((l + h) * p);
    return pos == (((l - 1) / 2) + 1) * p - 1;
  endfunction

  function automatic bit expHighStb(int t, int p, int l, int h);
    int pos = t % ((l + h) * p);
    return pos == l * p + (((h - 1) / 2) + 1) * p - 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runScenario(int pre, int hi, int lo, string req);
    int p = effVal(pre);
    int l = effVal(lo);
    int h = effVal(hi);
    int total = 2 * (l + h) * p;
    int badLo = 0, badHi = 0, badTick = 0, badLs = 0, badHs = 0, badBoth = 0;
    int firstLvl;
    @(negedge clk);
    prescale = 7'(pre);
    divider  = {8'(hi), 8'(lo)};
    enable   = 1'b1;
    clkReq   = 1'b1;
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      if (t == 0) firstLvl = int'(sclOut);
      if (sclOut != expScl(t, p, l, h)) begin
        if (expScl(t, p, l, h)) badHi++; else badLo++;
      end
      if (refTick != expTick(t, p)) badTick++;
      if (lowMidStb != expLowStb(t, p, l, h)) badLs++;
      if (highMidStb != expHighStb(t, p, l, h)) badHs++;
      if (lowMidStb && highMidStb) badBoth++;
    end
    // R5: starts in the low phase
    check(firstLvl == 0, {"R5 start low ", req}, firstLvl, 0);
    // R3: low phase length; R4: high phase length (two periods each)
    check(badLo == 0, {"R3 low phase ", req}, badLo, 0);
    check(badHi == 0, {"R4 high phase ", req}, badHi, 0);
    // R2: tick spacing
    check(badTick == 0, {"R2 tick spacing ", req}, badTick, 0);
    // R8 / R9: midpoint strobes
    check(badLs == 0, {"R8 low strobe ", req}, badLs, 0);
    check(badHs == 0, {"R9 high strobe ", req}, badHs, 0);
    // R10: exclusivity
    check(badBoth == 0, {"R10 exclusive ", req}, badBoth, 0);
  endtask

  task automatic deactivate(bit useReq);
    int bad = 0;
    @(negedge clk);
    if (useReq) clkReq = 1'b0; else enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!sclOut || refTick || lowMidStb || highMidStb) bad++;
    end
    // R7: idle state at the ports
    check(bad == 0, useReq ? "R7 request dropped" : "R7 enable dropped", bad, 0);
    enable = 1'b0;
    clkReq = 1'b0;
  endtask

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd20240611));
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclOut && !refTick && !lowMidStb && !highMidStb, "R1 in reset",
          {sclOut, refTick, lowMidStb, highMidStb}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOut && !refTick && !lowMidStb && !highMidStb, "R1 after reset",
          {sclOut, refTick, lowMidStb, highMidStb}, 4'b1000);

    // directed corners
    runScenario(0, 13, 13, "R2 prescale zero");
    deactivate(1'b0);
    runScenario(1, 255, 13, "widest high");
    deactivate(1'b1);
    runScenario(3, 0, 0, "R6 zero fields");
    deactivate(1'b0);
    runScenario(2, 1, 2, "short halves");
    deactivate(1'b1);
    runScenario(5, 4, 0, "R6 zero low");
    deactivate(1'b0);

    // constrained random settings
    for (int k = 0; k < 8; k++) begin
      int rp = int'($urandom_range(1, 7));
      int rh = int'($urandom_range(1, 40));
      int rl = int'($urandom_range(1, 40));
      runScenario(rp, rh, rl, "random");
      deactivate(k[0]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule